// File: doc/BRIEF.md
# Copy Authorization Checker

This block decides whether a request to commit scratchpad contents to nonvolatile memory may go ahead. After the command decoder reports a copy command code, the block collects the next three bytes from the host. These bytes must echo, in order, the low target-address byte, the high target-address byte and the ending-offset/status byte. It compares each byte with the live register values as they arrive.

At the third byte the block also checks that the partial-byte flag is clear, that the target is not copy-protected and that no memory read has broken the write sequence. If every condition holds, it raises the authorization-accepted flag and gives the external programming sequencer a single-cycle start pulse. A host that sent an out-of-range address and did not read back the folded value sends the wrong high address byte, so its copy is refused. The block also keeps the bad-sequence flag: any memory read sets it, and a complete write-scratchpad address clears it.

Top module: `copy_auth_checker`

## Requirements
- R1: After reset, `aa_flag`, `bs_flag` and `copy_start` are all 0.
- R2: After `cmd_valid` with `cmd_code` equal to the parameter `COPY_CMD` (default 8'h55), three `rx_valid` bytes equal to `ta_reg[7:0]`, `ta_reg[15:8]` and the status byte {`aa_flag`, 1'b0, `pf_flag`, `end_off[4:0]`} make `copy_start` 1 and `aa_flag` 1 in the cycle after the third byte.
- R3: If any of the three bytes differs from its expected value (including a high address byte that does not match the folded `ta_reg`), there is no start pulse and `aa_flag` keeps its value.
- R4: With `pf_flag` = 1 at the third byte, the copy is refused: no start pulse and `aa_flag` unchanged.
- R5: With `copy_protect` = 1 at the third byte, the copy is refused: no start pulse and `aa_flag` unchanged.
- R6: `mem_read_cmd` sets `bs_flag` in the next cycle. `wr_addr_done` clears it, but `mem_read_cmd` wins when both arrive in the same cycle. While `bs_flag` is 1, the copy is refused.
- R7: `wrsp_start` clears `aa_flag` in the next cycle.
- R8: `bus_reset`, or a `cmd_valid` with any other code, before the third byte abandons the sequence. Bytes that follow do not complete it.
- R9: Bytes with no copy command open, and bytes after the third, are ignored.
- R10: `copy_start` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command code byte present on `cmd_code` |
| cmd_code | input | 8 | Command code |
| rx_valid | input | 1 | Data byte present on `rx_byte` |
| rx_byte | input | 8 | Data byte from the host |
| bus_reset | input | 1 | Host ended the transaction |
| wrsp_start | input | 1 | A write-scratchpad command began |
| wr_addr_done | input | 1 | Write-scratchpad target address fully received |
| mem_read_cmd | input | 1 | A memory read command was received |
| ta_reg | input | ADDR_W | Stored target address |
| end_off | input | OFF_W | Stored ending offset |
| pf_flag | input | 1 | Partial-byte flag |
| copy_protect | input | 1 | Target page is copy-protected |
| aa_flag | output | 1 | Authorization accepted |
| bs_flag | output | 1 | Bad sequence seen since the last address |
| copy_start | output | 1 | One-cycle start request to the programming sequencer |

## Verification
On every cycle, the assertions check that the start pulse lasts one cycle and always comes with AA set. They also check that it follows a data byte received while PF, protection and BS were all clear, that AA rises only with a start pulse and falls only after a write-scratchpad, and how BS follows reads and completed addresses. Whether the three echoed bytes are compared against the right register in the right order can only be shown by the bench's scenarios. The same holds for a folded high address being refused, for aborts mid-sequence and for trailing bytes being ignored.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_COLLECT = 1'b1} seq_state_t;
endpackage

// File: rtl/cpa_expect.sv
module cpa_expect
  import cpa_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NB     = ADDR_W / BYTE_W + 1,
  parameter int CW     = $clog2(NB)
) (
  input  logic [ADDR_W-1:0] ta_reg,
  input  byte_t             es_byte,
  input  logic [CW-1:0]     idx,
  output byte_t             exp_byte
);
  byte_t seq_bytes [NB];

  genvar g;
  generate
    for (g = 0; g < NB - 1; g++) begin : g_addr
      assign seq_bytes[g] = ta_reg[g*BYTE_W +: BYTE_W];
    end
  endgenerate
  assign seq_bytes[NB-1] = es_byte;

  always_comb begin
    exp_byte = '0;
    for (int i = 0; i < NB; i++) begin
      if (idx == CW'(i)) exp_byte = seq_bytes[i];
    end
  end
endmodule

// File: rtl/cpa_seq.sv
module cpa_seq
  import cpa_pkg::*;
#(
  parameter byte_t COPY_CMD = 8'h55,
  parameter int    NB       = 3,
  parameter int    CW       = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  byte_t         cmd_code,
  input  logic          rx_valid,
  input  byte_t         rx_byte,
  input  logic          bus_reset,
  input  byte_t         exp_byte,
  input  logic          permit,
  output logic [CW-1:0] idx,
  output logic          grant
);
  seq_state_t    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ok_q, ok_n;
  logic          hit;

  assign idx = cnt_q;
  assign hit = (rx_byte == exp_byte);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    ok_n  = ok_q;
    grant = 1'b0;
    if (bus_reset) begin
      st_n = SEQ_IDLE;
    end else if (cmd_valid) begin
      st_n  = (cmd_code == COPY_CMD) ? SEQ_COLLECT : SEQ_IDLE;
      cnt_n = '0;
      ok_n  = 1'b1;
    end else if (rx_valid && st_q == SEQ_COLLECT) begin
      if (cnt_q == CW'(NB - 1)) begin
        grant = ok_q && hit && permit;
        st_n  = SEQ_IDLE;
      end else begin
        cnt_n = cnt_q + 1'b1;
        ok_n  = ok_q && hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      ok_q  <= ok_n;
    end
  end
endmodule

// File: rtl/cpa_flags.sv
module cpa_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic wrsp_start,
  input  logic wr_addr_done,
  input  logic mem_read_cmd,
  output logic aa_q,
  output logic bs_q,
  output logic start_q
);
  logic aa_n, bs_n, aa_en, bs_en;

  always_comb begin
    aa_en = grant || wrsp_start;
    aa_n  = grant;
    bs_en = mem_read_cmd || wr_addr_done;
    bs_n  = mem_read_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aa_q    <= 1'b0;
      bs_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= grant;
      if (aa_en) aa_q <= aa_n;
      if (bs_en) bs_q <= bs_n;
    end
  end
endmodule

// File: rtl/copy_auth_checker.sv
module copy_auth_checker
  import cpa_pkg::*;
#(
  parameter int    ADDR_W   = 16,
  parameter int    OFF_W    = 5,
  parameter byte_t COPY_CMD = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              bus_reset,
  input  logic              wrsp_start,
  input  logic              wr_addr_done,
  input  logic              mem_read_cmd,
  input  logic [ADDR_W-1:0] ta_reg,
  input  logic [OFF_W-1:0]  end_off,
  input  logic              pf_flag,
  input  logic              copy_protect,
  output logic              aa_flag,
  output logic              bs_flag,
  output logic              copy_start
);
  localparam int NB  = ADDR_W / BYTE_W + 1;
  localparam int CW  = $clog2(NB);
  localparam int PAD = BYTE_W - 2 - OFF_W;

  byte_t         es_byte, exp_byte;
  logic [CW-1:0] idx;
  logic          grant, permit;

  assign es_byte = {aa_flag, {PAD{1'b0}}, pf_flag, end_off};
  assign permit  = !pf_flag && !copy_protect && !bs_flag;

  cpa_expect #(.ADDR_W(ADDR_W), .NB(NB), .CW(CW)) u_expect (
    .ta_reg(ta_reg), .es_byte(es_byte), .idx(idx), .exp_byte(exp_byte)
  );

  cpa_seq #(.COPY_CMD(COPY_CMD), .NB(NB), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .bus_reset(bus_reset),
    .exp_byte(exp_byte), .permit(permit), .idx(idx), .grant(grant)
  );

  cpa_flags u_flags (
    .clk(clk), .rst_n(rst_n), .grant(grant), .wrsp_start(wrsp_start),
    .wr_addr_done(wr_addr_done), .mem_read_cmd(mem_read_cmd),
    .aa_q(aa_flag), .bs_q(bs_flag), .start_q(copy_start)
  );
endmodule

// File: rtl/copy_auth_checker_sva.sv
module copy_auth_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic wrsp_start,
  input logic wr_addr_done,
  input logic mem_read_cmd,
  input logic pf_flag,
  input logic copy_protect,
  input logic aa_flag,
  input logic bs_flag,
  input logic copy_start
);
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |=> !copy_start);

  p_start_sets_aa_r2: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |-> aa_flag);

  p_aa_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aa_flag) |-> copy_start);

  p_start_pf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |-> $past(rx_valid && !pf_flag));

  p_start_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |-> $past(!copy_protect && !bs_flag));

  p_bs_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_read_cmd |=> bs_flag);

  p_bs_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr_done && !mem_read_cmd) |=> !bs_flag);

  p_aa_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aa_flag) |-> $past(wrsp_start));
endmodule

bind copy_auth_checker copy_auth_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .wrsp_start(wrsp_start),
  .wr_addr_done(wr_addr_done), .mem_read_cmd(mem_read_cmd),
  .pf_flag(pf_flag), .copy_protect(copy_protect), .aa_flag(aa_flag),
  .bs_flag(bs_flag), .copy_start(copy_start)
);

// File: tb/test_copy_auth_checker.sv
module test_copy_auth_checker;
  localparam logic [7:0] CPY = 8'h55;

  logic clk, rst_n;
  logic cmd_valid, rx_valid, bus_reset, wrsp_start, wr_addr_done, mem_read_cmd;
  logic [7:0] cmd_code, rx_byte;
  logic [15:0] ta_reg;
  logic [4:0] end_off;
  logic pf_flag, copy_protect;
  logic aa_flag, bs_flag, copy_start;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  copy_auth_checker i_copy_auth_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .bus_reset(bus_reset),
    .wrsp_start(wrsp_start), .wr_addr_done(wr_addr_done),
    .mem_read_cmd(mem_read_cmd), .ta_reg(ta_reg), .end_off(end_off),
    .pf_flag(pf_flag), .copy_protect(copy_protect), .aa_flag(aa_flag),
    .bs_flag(bs_flag), .copy_start(copy_start)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] es(logic aa);
    return {aa, 1'b0, pf_flag, end_off};
  endfunction

  task automatic send_cmd(logic [7:0] c);
    @(negedge clk); cmd_valid = 1; cmd_code = c;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic pulse_wrsp;
    @(negedge clk); wrsp_start = 1;
    @(negedge clk); wrsp_start = 0;
  endtask

  task automatic copy_seq(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    send_cmd(CPY); send_byte(b0); send_byte(b1); send_byte(b2);
  endtask

  task automatic t_reset;
    check("R1 aa", aa_flag, 0);
    check("R1 bs", bs_flag, 0);
    check("R1 start", copy_start, 0);
  endtask

  task automatic t_good;
    copy_seq(ta_reg[7:0], ta_reg[15:8], es(1'b0));
    check("R2 start", copy_start, 1);
    check("R2 aa", aa_flag, 1);
    @(negedge clk);
    check("R10 pulse ends", copy_start, 0);
    send_byte(ta_reg[7:0]);
    check("R9 trailing byte", copy_start, 0);
  endtask

  task automatic t_mismatch;
    // aa is 1 here; folded high address mismatch (sent 0x1A, stored 0x0A)
    copy_seq(ta_reg[7:0], ta_reg[15:8] | 8'h10, es(1'b1));
    check("R3 start", copy_start, 0);
    check("R3 aa kept", aa_flag, 1);
    copy_seq(ta_reg[7:0], ta_reg[15:8], es(1'b0));
    check("R3 es mismatch", copy_start, 0);
  endtask

  task automatic t_aa_clear;
    pulse_wrsp;
    check("R7 aa cleared", aa_flag, 0);
  endtask

  task automatic t_pf;
    pf_flag = 1;
    copy_seq(ta_reg[7:0], ta_reg[15:8], es(1'b0));
    check("R4 start", copy_start, 0);
    check("R4 aa", aa_flag, 0);
    pf_flag = 0;
  endtask

  task automatic t_prot;
    copy_protect = 1;
    copy_seq(ta_reg[7:0], ta_reg[15:8], es(1'b0));
    check("R5 start", copy_start, 0);
    check("R5 aa", aa_flag, 0);
    copy_protect = 0;
  endtask

  task automatic t_bs;
    @(negedge clk); mem_read_cmd = 1;
    @(negedge clk); mem_read_cmd = 0;
    check("R6 bs set", bs_flag, 1);
    copy_seq(ta_reg[7:0], ta_reg[15:8], es(1'b0));
    check("R6 refused", copy_start, 0);
    @(negedge clk); wr_addr_done = 1;
    @(negedge clk); wr_addr_done = 0;
    check("R6 bs cleared", bs_flag, 0);
    @(negedge clk); wr_addr_done = 1; mem_read_cmd = 1;
    @(negedge clk); wr_addr_done = 0; mem_read_cmd = 0;
    check("R6 read wins", bs_flag, 1);
    @(negedge clk); wr_addr_done = 1;
    @(negedge clk); wr_addr_done = 0;
  endtask

  task automatic t_abort;
    send_cmd(CPY); send_byte(ta_reg[7:0]);
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
    send_byte(ta_reg[15:8]); send_byte(es(1'b0));
    check("R8 bus reset", copy_start, 0);
    send_cmd(CPY); send_byte(ta_reg[7:0]); send_cmd(8'hAA);
    send_byte(ta_reg[15:8]); send_byte(es(1'b0));
    check("R8 other cmd", copy_start, 0);
    check("R8 aa", aa_flag, 0);
  endtask

  task automatic t_nocmd;
    send_byte(ta_reg[7:0]); send_byte(ta_reg[15:8]); send_byte(es(1'b0));
    check("R9 no command", copy_start, 0);
    copy_seq(ta_reg[7:0], ta_reg[15:8], es(1'b0));
    check("R2 second copy", copy_start, 1);
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; rx_valid = 0; bus_reset = 0; wrsp_start = 0;
    wr_addr_done = 0; mem_read_cmd = 0; cmd_code = 0; rx_byte = 0;
    ta_reg = 16'h0A25; end_off = 5'h1F; pf_flag = 0; copy_protect = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_good;
    t_mismatch;
    t_aa_clear;
    t_pf;
    t_prot;
    t_bs;
    t_abort;
    t_nocmd;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule